// File: doc/BRIEF.md
# First and Next Error Logging Pair

This block is the error log kept inside one unit. It watches three groups of single-cycle error events: received error messages, errors detected inside the unit, and device errors. It records them in two sticky registers. The first-error register takes the error, or the set of simultaneous errors, that arrives while it is empty. From then on, every later error is recorded only in the next-error register. Recording does not depend on any masking or signalling enable, so the log shows what happened whether or not anything was reported.

Two pointers sit beside the registers. The uncorrectable pointer captures the index of the first uncorrectable error that is enabled for reporting. The correctable pointer captures the index of the first correctable error that is not masked. Software clears bits through a write-one-to-clear port aimed at one of the two registers. A pointer re-arms once software has cleared the bit it points at from both registers. A summary flag shows that any bit is set in either register, for use by a unit-level aggregation outside this block.

Top module: `errlog_pair`

## Requirements
- R1: After reset, both registers read zero, both pointer valid flags are low, and `any_err` is low.
- R2: The combined error index places `rcv_err[k]` at bit k, `int_err[k]` at bit N_RCV+k, and `dev_err[k]` at bit N_RCV+N_INT+k, in both registers and in both pointers.
- R3: When the first-error register is zero at a clock edge, every error present in that cycle sets its bit in the first-error register and leaves the next-error register unchanged. This holds again once software has emptied the first-error register.
- R4: When the first-error register is non-zero at a clock edge, errors in that cycle set bits only in the next-error register, and the first-error register keeps its value.
- R5: Logging into either register is unaffected by `unc_en`, `unc_sel` and `cor_mask`.
- R6: A cycle with `clr_wr` high clears, in the register chosen by `clr_tgt` (0 = first, 1 = next), each bit where `clr_bits` is 1. All other bits and the other register are left unchanged.
- R7: If an error sets a bit in the same cycle that a clear targets that bit, the bit ends up set.
- R8: While invalid, the uncorrectable pointer captures the lowest index among that cycle's errors with `unc_sel` and `unc_en` both 1, and becomes valid. While valid, later errors do not change it.
- R9: While invalid, the correctable pointer captures the lowest index among that cycle's errors with `unc_sel` 0 and `cor_mask` 0, and becomes valid. While valid, later errors do not change it.
- R10: A valid pointer becomes invalid at the edge after which the bit it indicates is zero in both registers. While it is valid, that bit is set in at least one of them.
- R11: `any_err` is high exactly when some bit is set in either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rcv_err | input | N_RCV | Received error message events |
| int_err | input | N_INT | Internally detected / unit-specific error events |
| dev_err | input | N_DEV | Device error events |
| unc_sel | input | W | Per-index class: 1 = uncorrectable, 0 = correctable |
| unc_en | input | W | Per-index reporting enable for uncorrectable errors |
| cor_mask | input | W | Per-index mask for correctable errors (1 = masked) |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_tgt | input | 1 | Clear target: 0 = first-error register, 1 = next-error register |
| clr_bits | input | W | Bits to clear in the targeted register |
| first_log | output | W | First-error register |
| next_log | output | W | Next-error register |
| unc_ptr | output | IDX_W | First enabled uncorrectable error index |
| unc_ptr_vld | output | 1 | Uncorrectable pointer valid |
| cor_ptr | output | IDX_W | First unmasked correctable error index |
| cor_ptr_vld | output | 1 | Correctable pointer valid |
| any_err | output | 1 | Some bit is set in either register |

## Verification
Every result is due one clock edge after its stimulus. An error or a clear presented in a cycle shows up in both registers, in both pointers, in the valid flags and in `any_err` just after the next rising edge. No internal stage adds further delay. The bench therefore applies each stimulus on a falling edge and holds it across exactly one rising edge. It compares all outputs with its reference model on the following falling edge, and removes the stimulus before the next rising edge so that every cycle carries only what the bench intended.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

  // Which of the two log registers a clear write is aimed at.
  typedef enum logic {
    LOG_FIRST = 1'b0,
    LOG_NEXT  = 1'b1
  } log_sel_e;

  // True when a clear strobe targets the bank identified by 'me'.
  function automatic logic clr_hits_bank(input logic wr, input log_sel_e tgt,
                                         input log_sel_e me);
    return wr && (tgt == me);
  endfunction

endpackage

// File: rtl/errlog_bank.sv
module errlog_bank #(
  parameter int W = 14,
  parameter errlog_pkg::log_sel_e SEL = errlog_pkg::LOG_FIRST
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W-1:0]          set_v,
  input  logic                  clr_wr,
  input  errlog_pkg::log_sel_e  clr_tgt,
  input  logic [W-1:0]          clr_bits,
  output logic [W-1:0]          q,
  output logic [W-1:0]          d
);
  import errlog_pkg::*;

  logic [W-1:0] clr_eff;

  assign clr_eff = clr_hits_bank(clr_wr, clr_tgt, SEL) ? clr_bits : '0;
  // New events win over a clear in the same cycle.
  assign d = (q & ~clr_eff) | set_v;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/errlog_route.sv
module errlog_route #(
  parameter int W = 14
) (
  input  logic [W-1:0] first_q,
  input  logic [W-1:0] err_vec,
  output logic         first_empty,
  output logic [W-1:0] set_first,
  output logic [W-1:0] set_next
);
  assign first_empty = (first_q == '0);
  assign set_first   = first_empty ? err_vec : '0;
  assign set_next    = first_empty ? '0 : err_vec;
endmodule

// File: rtl/errlog_ptr.sv
module errlog_ptr #(
  parameter int W     = 14,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     qual,
  input  logic [W-1:0]     first_d,
  input  logic [W-1:0]     next_d,
  output logic [IDX_W-1:0] ptr,
  output logic             vld,
  output logic             cap_ev,
  output logic             rearm_ev
);
  // Returns {found, index of the lowest set bit}.
  function automatic logic [IDX_W:0] lowest_set(input logic [W-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (v[i] && !r[IDX_W]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  logic [IDX_W:0] pick;

  assign pick     = lowest_set(qual);
  assign rearm_ev = vld && !first_d[ptr] && !next_d[ptr];
  assign cap_ev   = !vld && pick[IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= 1'b0;
      ptr <= '0;
    end else if (rearm_ev) begin
      vld <= 1'b0;
    end else if (cap_ev) begin
      vld <= 1'b1;
      ptr <= pick[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/errlog_pair.sv
module errlog_pair #(
  parameter  int N_RCV = 4,
  parameter  int N_INT = 6,
  parameter  int N_DEV = 4,
  localparam int W     = N_RCV + N_INT + N_DEV,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_RCV-1:0] rcv_err,
  input  logic [N_INT-1:0] int_err,
  input  logic [N_DEV-1:0] dev_err,
  input  logic [W-1:0]     unc_sel,
  input  logic [W-1:0]     unc_en,
  input  logic [W-1:0]     cor_mask,
  input  logic             clr_wr,
  input  logic             clr_tgt,
  input  logic [W-1:0]     clr_bits,
  output logic [W-1:0]     first_log,
  output logic [W-1:0]     next_log,
  output logic [IDX_W-1:0] unc_ptr,
  output logic             unc_ptr_vld,
  output logic [IDX_W-1:0] cor_ptr,
  output logic             cor_ptr_vld,
  output logic             any_err
);
  import errlog_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [W-1:0] err_vec;
  logic         first_empty;
  logic [W-1:0] set_first, set_next;
  logic [W-1:0] first_d, next_d;
  logic [W-1:0] unc_qual, cor_qual;
  logic         unc_cap_ev, unc_rearm_ev, cor_cap_ev, cor_rearm_ev;
  log_sel_e     tgt;

  assign err_vec  = {dev_err, int_err, rcv_err};
  assign tgt      = log_sel_e'(clr_tgt);
  assign unc_qual = err_vec &  unc_sel &  unc_en;
  assign cor_qual = err_vec & ~unc_sel & ~cor_mask;

  errlog_route #(.W(W)) u_route (
    .first_q    (first_log),
    .err_vec    (err_vec),
    .first_empty(first_empty),
    .set_first  (set_first),
    .set_next   (set_next)
  );

  errlog_bank #(.W(W), .SEL(LOG_FIRST)) u_first (
    .clk(clk), .rst_n(rst_n), .set_v(set_first), .clr_wr(clr_wr),
    .clr_tgt(tgt), .clr_bits(clr_bits), .q(first_log), .d(first_d)
  );

  errlog_bank #(.W(W), .SEL(LOG_NEXT)) u_next (
    .clk(clk), .rst_n(rst_n), .set_v(set_next), .clr_wr(clr_wr),
    .clr_tgt(tgt), .clr_bits(clr_bits), .q(next_log), .d(next_d)
  );

  errlog_ptr #(.W(W), .IDX_W(IDX_W)) u_unc_ptr (
    .clk(clk), .rst_n(rst_n), .qual(unc_qual), .first_d(first_d), .next_d(next_d),
    .ptr(unc_ptr), .vld(unc_ptr_vld), .cap_ev(unc_cap_ev), .rearm_ev(unc_rearm_ev)
  );

  errlog_ptr #(.W(W), .IDX_W(IDX_W)) u_cor_ptr (
    .clk(clk), .rst_n(rst_n), .qual(cor_qual), .first_d(first_d), .next_d(next_d),
    .ptr(cor_ptr), .vld(cor_ptr_vld), .cap_ev(cor_cap_ev), .rearm_ev(cor_rearm_ev)
  );

  assign any_err = (|first_log) | (|next_log);
endmodule

// File: rtl/errlog_pair_chk.sv
module errlog_pair_chk #(
  parameter int W     = 14,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     err_vec,
  input logic             clr_wr,
  input logic [W-1:0]     first_log,
  input logic [W-1:0]     next_log,
  input logic [IDX_W-1:0] unc_ptr,
  input logic             unc_ptr_vld,
  input logic [IDX_W-1:0] cor_ptr,
  input logic             cor_ptr_vld,
  input logic             any_err
);
  // R3: an empty first register takes exactly that cycle's errors.
  assert_first_takes_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (first_log == '0 && !clr_wr) |=> (first_log == $past(err_vec)));

  // R3: the next register is untouched while first is empty.
  assert_next_quiet_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (first_log == '0 && !clr_wr) |=> (next_log == $past(next_log)));

  // R4: a non-empty first register is frozen without a clear.
  assert_first_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (first_log != '0 && !clr_wr) |=> (first_log == $past(first_log)));

  // R8: a valid uncorrectable pointer does not move.
  assert_unc_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unc_ptr_vld |=> (!unc_ptr_vld || $stable(unc_ptr)));

  // R9: a valid correctable pointer does not move.
  assert_cor_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cor_ptr_vld |=> (!cor_ptr_vld || $stable(cor_ptr)));

  // R10: a valid pointer always names a logged bit.
  assert_unc_ptr_backed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unc_ptr_vld |-> (first_log[unc_ptr] || next_log[unc_ptr]));

  assert_cor_ptr_backed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cor_ptr_vld |-> (first_log[cor_ptr] || next_log[cor_ptr]));

  // R11: the summary stays up until software clears something.
  assert_any_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && !clr_wr) |=> any_err);
endmodule

bind errlog_pair errlog_pair_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_vec(err_vec), .clr_wr(clr_wr),
  .first_log(first_log), .next_log(next_log),
  .unc_ptr(unc_ptr), .unc_ptr_vld(unc_ptr_vld),
  .cor_ptr(cor_ptr), .cor_ptr_vld(cor_ptr_vld), .any_err(any_err)
);

// File: tb/errlog_pair_bench.sv
module errlog_pair_bench;
  localparam int N_RCV = 4, N_INT = 6, N_DEV = 4;
  localparam int W = N_RCV + N_INT + N_DEV;
  localparam int IDX_W = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_RCV-1:0] rcv_err = '0;
  logic [N_INT-1:0] int_err = '0;
  logic [N_DEV-1:0] dev_err = '0;
  logic [W-1:0] unc_sel = '0, unc_en = '0, cor_mask = '0, clr_bits = '0;
  logic clr_wr = 1'b0, clr_tgt = 1'b0;
  logic [W-1:0] first_log, next_log;
  logic [IDX_W-1:0] unc_ptr, cor_ptr;
  logic unc_ptr_vld, cor_ptr_vld, any_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [W-1:0] m_first, m_next;
  int m_uptr, m_cptr;
  bit m_uvld, m_cvld;

  always #10 clk = ~clk;

  errlog_pair u_errlog_pair (
    .clk(clk), .rst_n(rst_n), .rcv_err(rcv_err), .int_err(int_err), .dev_err(dev_err),
    .unc_sel(unc_sel), .unc_en(unc_en), .cor_mask(cor_mask),
    .clr_wr(clr_wr), .clr_tgt(clr_tgt), .clr_bits(clr_bits),
    .first_log(first_log), .next_log(next_log),
    .unc_ptr(unc_ptr), .unc_ptr_vld(unc_ptr_vld),
    .cor_ptr(cor_ptr), .cor_ptr_vld(cor_ptr_vld), .any_err(any_err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scans from the top down; the last hit is the lowest index.
  function automatic int lowest(input logic [W-1:0] v);
    int r = -1;
    for (int i = W - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " first_log"}, first_log, m_first);
    chk({tag, " next_log"}, next_log, m_next);
    chk("R11 any_err", any_err, (m_first | m_next) != '0);
    chk("R8 unc_ptr_vld", unc_ptr_vld, m_uvld);
    if (m_uvld) chk("R8 unc_ptr", unc_ptr, m_uptr);
    chk("R9 cor_ptr_vld", cor_ptr_vld, m_cvld);
    if (m_cvld) chk("R9 cor_ptr", cor_ptr, m_cptr);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_first = '0; m_next = '0; m_uvld = 0; m_cvld = 0; m_uptr = 0; m_cptr = 0;
    check_all("R1");
  endtask

  // One cycle of stimulus, applied on a falling edge and checked on the next.
  task automatic step(input logic [W-1:0] v, input logic wr, input logic tgt,
                      input logic [W-1:0] bits, input string tag);
    logic [W-1:0] nf, nn, uq, cq;
    rcv_err = v[N_RCV-1:0];
    int_err = v[N_RCV +: N_INT];
    dev_err = v[N_RCV+N_INT +: N_DEV];
    clr_wr = wr; clr_tgt = tgt; clr_bits = bits;
    nf = m_first; nn = m_next;
    if (wr && !tgt) nf = nf & ~bits;
    if (wr &&  tgt) nn = nn & ~bits;
    if (m_first == '0) nf = nf | v; else nn = nn | v;
    uq = v & unc_sel & unc_en;
    cq = v & ~unc_sel & ~cor_mask;
    if (m_uvld) begin
      if (!nf[m_uptr] && !nn[m_uptr]) m_uvld = 0;
    end else if (uq != '0) begin
      m_uvld = 1; m_uptr = lowest(uq);
    end
    if (m_cvld) begin
      if (!nf[m_cptr] && !nn[m_cptr]) m_cvld = 0;
    end else if (cq != '0) begin
      m_cvld = 1; m_cptr = lowest(cq);
    end
    m_first = nf; m_next = nn;
    @(posedge clk);
    @(negedge clk);
    rcv_err = '0; int_err = '0; dev_err = '0; clr_wr = 1'b0; clr_bits = '0;
    check_all(tag);
  endtask

  initial begin
    for (int i = 0; i < W; i++) begin
      unc_sel[i]  = (i % 3 == 0);
      unc_en[i]   = (i % 2 == 0);
      cor_mask[i] = (i % 4 == 1);
    end
    do_reset();

    // Sweep all ordered pairs of single errors (R2, R3, R4, R6, R10).
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        do_reset();
        step(W'(1) << i, 0, 0, '0, "R2 R3");
        step(W'(1) << j, 0, 0, '0, "R4");
        step('0, 1, 0, W'(1) << i, "R6 R10");
        step(W'(1) << ((i + j) % W), 0, 0, '0, "R3 refill");
      end
    end

    // Several simultaneous errors into an empty first register (R3).
    do_reset();
    step(14'h2A5, 0, 0, '0, "R3 burst");
    step(14'h1803, 0, 0, '0, "R4 burst");
    // Partial clear of next, then of first (R6).
    step('0, 1, 1, 14'h0801, "R6 next partial");
    step('0, 1, 0, 14'h0205, "R6 first partial");
    // Set and clear of the same next bit in one cycle (R7).
    step(14'h1000, 1, 1, 14'h1000, "R7");
    step('0, 1, 1, 14'h3FFF, "R6 clear next all");
    step('0, 1, 0, 14'h3FFF, "R6 clear first all");
    step(14'h0040, 0, 0, '0, "R3 after empty");

    // Enables and masks do not change logging (R5).
    unc_en = '0; cor_mask = '1;
    do_reset();
    step(14'h3FFF, 0, 0, '0, "R5 first");
    step(14'h3FFF, 0, 0, '0, "R5 next");
    unc_sel = '1; unc_en = '1; cor_mask = '0;
    do_reset();
    step(14'h0300, 0, 0, '0, "R5 R8 all unc");
    step(14'h0001, 0, 0, '0, "R8 hold");
    step('0, 1, 0, 14'h0100, "R10 rearm");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule